// File: doc/BRIEF.md
# Flash buffered write sequencer

This block drives one buffered program operation on a parallel NOR flash. A single shared command bus carries both commands and data. The caller gives a start address, a byte count and a stream of data words. The sequencer then talks to the device until the program completes or fails.

First it puts the device into status mode and clears any sticky error bits that would block a buffered write. It then asks for the device's write buffer, retrying a bounded number of times. Next it sends the word count and writes the data words, padding a short last word with 0xFF. Finally it issues the confirm command, waits an adaptive number of cycles, and polls status until the device reports ready.

The caller must keep each transfer inside one write-buffer window. A transfer that would cross the window edge, starts off a word boundary, or has zero length is refused at once. The outcome is reported as a code with a one-cycle done pulse.

Top module: `flash_bufwr_seq`

## Requirements
- R1: A start with zero length, a start address not aligned to the bus width, or a range crossing a BUF_BYTES window is refused. The block issues no bus access, raises done on the next cycle, and reports code 3.
- R2: All command and count writes go to the start address with its low log2(BUF_BYTES) bits cleared. When `stat_mode` is low, 0x70 is written first. A status read follows in both cases.
- R3: If that status read shows bit 4 or bit 5 set, 0x50 and then 0x70 are written before the buffer request.
- R4: The buffer request writes 0xE8 and then reads status, and is repeated until bit 7 is set. After MAX_REQ requests without bit 7, the block writes 0x50 and 0x70 and reports code 1.
- R5: After a granted request, the count word written is ceil(len/BW) − 1. This is the number of full words minus one when len is a multiple of BW, and the number of full words otherwise.
- R6: Word k is written to start+k·BW, once per accepted `din_valid`/`din_ready` handshake, and stalls on the stream are tolerated. Byte lane i is bits 8i+7:8i, and lanes past the end of the byte count are set to 0xFF. A write and a read never happen in the same cycle.
- R7: After the data, 0xD0 is written. The first status poll comes wait_est+1 cycles after that write.
- R8: A poll with bit 7 set ends the operation. If bit 1 is also set, the block writes 0x50 and 0x70 and reports code 2; otherwise it reports code 0.
- R9: On completion, wait_est drops by one (never below 1) if no poll saw the device busy. It rises by one if more than one poll saw it busy, and stays the same if exactly one did.
- R10: After POLL_LIMIT busy polls, the block reports code 4 with no further writes and leaves wait_est unchanged.
- R11: After reset, busy, done, din_ready, fl_we, fl_re and err_code are 0, and wait_est equals EST_INIT.
- R12: done is a single-cycle pulse, and err_code is valid with it and held while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| start_addr | input | ADDR_W | Byte address of the first word |
| byte_len | input | LEN_W | Number of bytes to program |
| stat_mode | input | 1 | Device is already in status mode |
| din_valid | input | 1 | Data word offered |
| din_data | input | DATA_W | Data word, byte lane i in bits 8i+7:8i |
| din_ready | output | 1 | Data word accepted this cycle if valid |
| fl_we | output | 1 | Bus write strobe |
| fl_re | output | 1 | Bus status read strobe |
| fl_addr | output | ADDR_W | Bus address |
| fl_wdata | output | DATA_W | Bus write data |
| fl_rstat | input | 8 | Status byte, valid the cycle after fl_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| err_code | output | 3 | 0 ok, 1 buffer not granted, 2 protected, 3 range, 4 timeout |
| wait_est | output | EST_W | Current pre-poll wait in cycles |

## Verification
Table rows vary length parity, window position and the device's replies. Even and odd lengths separate the two count encodings and the 0xFF padding. A row that fills a window exactly and one that crosses it by a byte pin the range rule down to its edge. Device replies of 0, 1, 2, 3, 19, 20 and 20+ busy answers tell the grant-at-last-try case apart from exhaustion, and separate the three wait-estimate moves from a timeout. Clean and stale-status rows with status mode on and off show which preamble writes appear. A run of quick completions then drives the estimate to its floor of 1.

// File: rtl/flash_bufwr_pkg.sv
package flash_bufwr_pkg;

  typedef enum logic [2:0] {
    FE_OK    = 3'd0,
    FE_IO    = 3'd1,
    FE_PROT  = 3'd2,
    FE_RANGE = 3'd3,
    FE_TMO   = 3'd4
  } fe_code_t;

  localparam logic [7:0] CMD_RDSTAT = 8'h70;
  localparam logic [7:0] CMD_CLRST  = 8'h50;
  localparam logic [7:0] CMD_BUFREQ = 8'hE8;
  localparam logic [7:0] CMD_GO     = 8'hD0;

  localparam logic [7:0] MSK_RDY    = 8'h80;
  localparam logic [7:0] MSK_STALE  = 8'h30;
  localparam logic [7:0] MSK_PROT   = 8'h02;

  typedef enum logic [4:0] {
    ST_IDLE, ST_STCMD, ST_STRD, ST_STCHK, ST_CLRA, ST_CLRB,
    ST_REQ, ST_REQRD, ST_REQCHK, ST_FCLRA, ST_FCLRB,
    ST_CNT, ST_DATA, ST_GO, ST_WAIT, ST_POLL, ST_POLLCHK,
    ST_PCLRA, ST_PCLRB, ST_DONE
  } st_t;

endpackage

// File: rtl/flash_bufwr_range.sv
module flash_bufwr_range #(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int BW        = 2,
  parameter int BUF_BYTES = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  last_o
);
  localparam int BW_LG = $clog2(BW);

  // in-window check: non-empty, word aligned, ends at or before window edge
  function automatic logic fits_window(input logic [ADDR_W-1:0] a,
                                       input logic [LEN_W-1:0]  n);
    int off;
    off = int'(a & ADDR_W'(BUF_BYTES-1));
    return (n != '0) && ((a & ADDR_W'(BW-1)) == '0) &&
           (off + int'(n) <= BUF_BYTES);
  endfunction

  // count word: ceil(n/BW)-1 == (n-1)/BW for n >= 1
  function automatic logic [LEN_W-1:0] count_word(input logic [LEN_W-1:0] n);
    return (n - LEN_W'(1)) >> BW_LG;
  endfunction

  function automatic logic [ADDR_W-1:0] window_base(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(BUF_BYTES-1);
  endfunction

  assign ok_o   = fits_window(addr_i, len_i);
  assign base_o = window_base(addr_i);
  assign last_o = count_word(len_i);

endmodule

// File: rtl/flash_bufwr_pack.sv
module flash_bufwr_pack #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int BW = DATA_W / 8;

  for (genvar k = 0; k < BW; k++) begin : g_lane
    assign word_o[8*k +: 8] = (LEN_W'(k) < rem_i) ? raw_i[8*k +: 8] : 8'hFF;
  end

endmodule

// File: rtl/flash_bufwr_est.sv
module flash_bufwr_est #(
  parameter int EST_W    = 6,
  parameter int EST_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             none_busy_i,
  input  logic             many_busy_i,
  output logic [EST_W-1:0] est_o
);
  localparam logic [EST_W-1:0] EST_MAX = {EST_W{1'b1}};

  logic [EST_W-1:0] est_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q <= EST_W'(EST_INIT);
    end else if (upd_i) begin
      if (none_busy_i && est_q > EST_W'(1)) est_q <= est_q - EST_W'(1);
      else if (many_busy_i && est_q != EST_MAX) est_q <= est_q + EST_W'(1);
    end
  end

  assign est_o = est_q;

  p_est_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    est_q != '0);

  p_est_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && none_busy_i && est_q > EST_W'(1)) |=> est_q == $past(est_q) - EST_W'(1));

  p_est_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i) |=> $stable(est_q));

endmodule

// File: rtl/flash_bufwr_seq.sv
module flash_bufwr_seq
  import flash_bufwr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 8,
  parameter int BUF_BYTES  = 32,
  parameter int MAX_REQ    = 20,
  parameter int POLL_LIMIT = 1000,
  parameter int EST_W      = 6,
  parameter int EST_INIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic              stat_mode,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [7:0]        fl_rstat,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [EST_W-1:0]  wait_est
);
  localparam int BW    = DATA_W / 8;
  localparam int TRY_W = $clog2(MAX_REQ + 1);
  localparam int PL_W  = $clog2(POLL_LIMIT + 1);

  st_t               st;
  logic [ADDR_W-1:0] cmd_q, addr_q;
  logic [LEN_W-1:0]  last_q, rem_q;
  logic [TRY_W-1:0]  tries_q;
  logic [PL_W-1:0]   poll_q;
  logic [EST_W-1:0]  wcnt_q;
  fe_code_t          err_q;

  // named internal events
  logic              rng_ok;
  logic [ADDR_W-1:0] rng_base;
  logic [LEN_W-1:0]  rng_last;
  logic              dev_ready, stale_seen, prot_seen;
  logic              last_beat, beat_fire;
  logic              est_upd, req_exhaust, poll_exhaust;
  logic [DATA_W-1:0] packed_word;
  logic [7:0]        cmd_byte;
  logic              cmd_wr;

  flash_bufwr_range #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BW(BW), .BUF_BYTES(BUF_BYTES)
  ) u_range (
    .addr_i(start_addr), .len_i(byte_len),
    .ok_o(rng_ok), .base_o(rng_base), .last_o(rng_last)
  );

  flash_bufwr_pack #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_pack (
    .raw_i(din_data), .rem_i(rem_q), .word_o(packed_word)
  );

  flash_bufwr_est #(.EST_W(EST_W), .EST_INIT(EST_INIT)) u_est (
    .clk(clk), .rst_n(rst_n), .upd_i(est_upd),
    .none_busy_i(poll_q == '0), .many_busy_i(poll_q > PL_W'(1)),
    .est_o(wait_est)
  );

  assign dev_ready    = (fl_rstat & MSK_RDY) != 8'h00;
  assign stale_seen   = (fl_rstat & MSK_STALE) != 8'h00;
  assign prot_seen    = (fl_rstat & MSK_PROT) != 8'h00;
  assign last_beat    = rem_q <= LEN_W'(BW);
  assign beat_fire    = (st == ST_DATA) && din_valid;
  assign est_upd      = (st == ST_POLLCHK) && dev_ready;
  assign req_exhaust  = tries_q == TRY_W'(MAX_REQ);
  assign poll_exhaust = poll_q == PL_W'(POLL_LIMIT - 1);

  always_comb begin
    cmd_wr   = 1'b1;
    cmd_byte = CMD_RDSTAT;
    unique case (st)
      ST_STCMD, ST_CLRB, ST_FCLRB, ST_PCLRB: cmd_byte = CMD_RDSTAT;
      ST_CLRA, ST_FCLRA, ST_PCLRA:           cmd_byte = CMD_CLRST;
      ST_REQ:                                cmd_byte = CMD_BUFREQ;
      ST_GO:                                 cmd_byte = CMD_GO;
      ST_CNT:                                cmd_byte = 8'h00;
      default:                               cmd_wr   = 1'b0;
    endcase
  end

  assign fl_we     = cmd_wr || beat_fire;
  assign fl_re     = (st == ST_STRD) || (st == ST_REQRD) || (st == ST_POLL);
  assign fl_addr   = (st == ST_DATA) ? addr_q : cmd_q;
  assign fl_wdata  = (st == ST_DATA) ? packed_word :
                     (st == ST_CNT)  ? DATA_W'(last_q) : DATA_W'(cmd_byte);
  assign din_ready = (st == ST_DATA);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign err_code  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      last_q  <= '0;
      rem_q   <= '0;
      tries_q <= '0;
      poll_q  <= '0;
      wcnt_q  <= '0;
      err_q   <= FE_OK;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          if (rng_ok) begin
            cmd_q   <= rng_base;
            last_q  <= rng_last;
            addr_q  <= start_addr;
            rem_q   <= byte_len;
            tries_q <= '0;
            st      <= stat_mode ? ST_STRD : ST_STCMD;
          end else begin
            err_q <= FE_RANGE;
            st    <= ST_DONE;
          end
        end
        ST_STCMD:  st <= ST_STRD;
        ST_STRD:   st <= ST_STCHK;
        ST_STCHK:  st <= stale_seen ? ST_CLRA : ST_REQ;
        ST_CLRA:   st <= ST_CLRB;
        ST_CLRB:   st <= ST_REQ;
        ST_REQ: begin
          tries_q <= tries_q + TRY_W'(1);
          st      <= ST_REQRD;
        end
        ST_REQRD:  st <= ST_REQCHK;
        ST_REQCHK: begin
          if (dev_ready)        st <= ST_CNT;
          else if (req_exhaust) st <= ST_FCLRA;
          else                  st <= ST_REQ;
        end
        ST_FCLRA:  st <= ST_FCLRB;
        ST_FCLRB: begin
          err_q <= FE_IO;
          st    <= ST_DONE;
        end
        ST_CNT:    st <= ST_DATA;
        ST_DATA: if (din_valid) begin
          addr_q <= addr_q + ADDR_W'(BW);
          rem_q  <= rem_q - LEN_W'(BW);
          if (last_beat) st <= ST_GO;
        end
        ST_GO: begin
          wcnt_q <= wait_est;
          poll_q <= '0;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt_q <= EST_W'(1)) st <= ST_POLL;
          else wcnt_q <= wcnt_q - EST_W'(1);
        end
        ST_POLL:   st <= ST_POLLCHK;
        ST_POLLCHK: begin
          if (dev_ready) begin
            if (prot_seen) begin
              err_q <= FE_PROT;
              st    <= ST_PCLRA;
            end else begin
              err_q <= FE_OK;
              st    <= ST_DONE;
            end
          end else if (poll_exhaust) begin
            err_q <= FE_TMO;
            st    <= ST_DONE;
          end else begin
            poll_q <= poll_q + PL_W'(1);
            st     <= ST_POLL;
          end
        end
        ST_PCLRA:  st <= ST_PCLRB;
        ST_PCLRB:  st <= ST_DONE;
        ST_DONE:   st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  p_range_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start && !rng_ok) |=> (done && err_code == FE_RANGE && !fl_we && !fl_re));

  p_req_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(MAX_REQ));

  p_no_bus_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_beat_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |-> (fl_we && fl_addr == addr_q));

  p_poll_after_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GO) |=> (!fl_re && !fl_we));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_err_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_code));

endmodule

// File: tb/flash_bufwr_seq_tb.sv
`timescale 1ns/1ps
module flash_bufwr_seq_tb;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int PLIM = 16;
  localparam int EINIT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] byte_len = '0;
  logic          stat_mode = 1'b0;
  logic          din_valid = 1'b0;
  logic [DW-1:0] din_data = '0;
  logic          din_ready;
  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [7:0]    fl_rstat = 8'h80;
  logic          busy, done;
  logic [2:0]    err_code;
  logic [5:0]    wait_est;

  always #4 clk = ~clk;

  flash_bufwr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .BUF_BYTES(32), .MAX_REQ(20),
    .POLL_LIMIT(PLIM), .EST_W(6), .EST_INIT(EINIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_len(byte_len), .stat_mode(stat_mode), .din_valid(din_valid),
    .din_data(din_data), .din_ready(din_ready), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rstat(fl_rstat), .busy(busy),
    .done(done), .err_code(err_code), .wait_est(wait_est)
  );

  // addr16 len8 sm stale busy5 polls5 prot err3
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0100, 8'd8,  1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 3'd0},
    {16'h0120, 8'd7,  1'b1, 1'b1, 5'd2,  5'd3,  1'b0, 3'd0},
    {16'h0144, 8'd28, 1'b0, 1'b0, 5'd0,  5'd1,  1'b1, 3'd2},
    {16'h0162, 8'd31, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 3'd3},
    {16'h0181, 8'd2,  1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 3'd3},
    {16'h01A0, 8'd0,  1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 3'd3},
    {16'h01C0, 8'd1,  1'b0, 1'b1, 5'd19, 5'd2,  1'b0, 3'd0},
    {16'h01E0, 8'd4,  1'b1, 1'b0, 5'd20, 5'd0,  1'b0, 3'd1},
    {16'h0200, 8'd3,  1'b0, 1'b0, 5'd0,  5'd20, 1'b0, 3'd4},
    {16'h0210, 8'd16, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 3'd0}
  };

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model and write log ----------------
  int          cyc = 0;
  int          k_busy = 0, k_polls = 0;
  bit          k_prot = 0;
  logic [1:0]  sr45 = 2'b00;
  int          phase = 0, req_n = 0, poll_n = 0, n_rd = 0;
  int          d0_cyc = -1, first_rd = -1;
  int          n_log = 0;
  logic [15:0] log_a [128];
  logic [15:0] log_d [128];

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (fl_we) begin
      if (n_log < 128) begin
        log_a[n_log] = fl_addr;
        log_d[n_log] = fl_wdata;
      end
      n_log++;
      if (fl_wdata == 16'h0050) sr45 = 2'b00;
      else if (fl_wdata == 16'h00E8) begin phase = 1; req_n++; end
      else if (fl_wdata == 16'h00D0) begin phase = 2; poll_n = 0; d0_cyc = cyc; first_rd = -1; end
    end
    if (fl_re) begin
      n_rd++;
      if (phase == 1) rdy = (req_n > k_busy);
      else if (phase == 2) begin
        rdy = (poll_n >= k_polls);
        poll_n++;
        if (first_rd < 0) first_rd = cyc;
      end else rdy = 1'b1;
      fl_rstat <= {rdy, 1'b0, sr45, 2'b00, (phase == 2) && rdy && k_prot, 1'b0};
    end
  end

  // ---------------- data stream driver ----------------
  int  didx = 0, vcnt = 0;
  bit  din_rst = 0;
  always begin
    bit hs;
    @(negedge clk);
    hs = din_valid && din_ready;
    @(posedge clk);
    #1;
    if (din_rst) begin didx = 0; din_rst = 0; end
    else if (hs) didx++;
    vcnt++;
    din_valid = (vcnt % 3) != 2;
    din_data  = {8'(8'h50 + didx), 8'(8'hA0 + didx)};
  end

  // ---------------- expected results ----------------
  int          exp_n;
  logic [15:0] exp_a [128];
  logic [15:0] exp_d [128];
  int          exp_est = EINIT;

  function automatic void push(input logic [15:0] a, input logic [15:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endfunction

  task automatic run_case(input logic [15:0] a, input logic [7:0] len,
                          input bit sm, input bit stale, input int busy_n,
                          input int polls, input bit prot, input logic [2:0] exp_err);
    logic [15:0] base;
    int nw, k, est_before, waitc;
    bit seen_done, reaches_go;
    exp_n = 0;
    base = a & ~16'h001F;
    est_before = exp_est;
    reaches_go = 0;
    if (exp_err != 3'd3) begin
      if (!sm) push(base, 16'h0070);
      if (stale) begin push(base, 16'h0050); push(base, 16'h0070); end
      for (int r = 0; r < ((busy_n >= 20) ? 20 : busy_n + 1); r++) push(base, 16'h00E8);
      if (busy_n >= 20) begin
        push(base, 16'h0050); push(base, 16'h0070);
      end else begin
        reaches_go = 1;
        nw = (int'(len) + 1) / 2;
        push(base, 16'(nw - 1));
        for (int w = 0; w < nw; w++)
          push(a + 16'(2*w), {((int'(len) - 2*w) == 1) ? 8'hFF : 8'(8'h50 + w), 8'(8'hA0 + w)});
        push(base, 16'h00D0);
        if (polls < PLIM) begin
          if (prot) begin push(base, 16'h0050); push(base, 16'h0070); end
          if (polls == 0) exp_est = (exp_est > 1) ? exp_est - 1 : 1;
          else if (polls > 1) exp_est = (exp_est < 63) ? exp_est + 1 : 63;
        end
      end
    end
    k_busy = busy_n; k_polls = polls; k_prot = prot;
    sr45 = stale ? 2'b11 : 2'b00;
    phase = 0; req_n = 0; n_log = 0; n_rd = 0; d0_cyc = -1; first_rd = -1;
    din_rst = 1;
    @(negedge clk);
    start = 1; start_addr = a; byte_len = len; stat_mode = sm;
    @(negedge clk);
    start = 0;
    k = 1;
    seen_done = done;
    waitc = 0;
    while (!seen_done && waitc < 3000) begin
      @(negedge clk);
      k++; waitc++;
      seen_done = done;
    end
    if (!seen_done) begin
      chk(0, "R12", "watchdog: done never seen", 0, 1);
      return;
    end
    chk(err_code == exp_err, (exp_err == 3'd3) ? "R1" : (exp_err == 3'd1) ? "R4" :
        (exp_err == 3'd2) ? "R8" : (exp_err == 3'd4) ? "R10" : "R8", "error code", err_code, exp_err);
    if (exp_err == 3'd3) begin
      chk(k == 1 && n_log == 0 && n_rd == 0, "R1", "refusal timing/no access", k, 1);
    end
    @(negedge clk);
    chk(!done && !busy && err_code == exp_err, "R12", "done pulse width / code held",
        {done, busy}, 0);
    chk(n_log == exp_n, "R2", "write count", n_log, exp_n);
    for (int i = 0; i < exp_n && i < n_log; i++) begin
      if (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i]) begin
        chk(0, (i < 3) ? "R3" : "R6", $sformatf("write %0d addr/data", i),
            {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
        break;
      end
    end
    chk(wait_est == 6'(exp_est), "R9", "wait estimate", wait_est, exp_est);
    if (reaches_go)
      chk(first_rd - d0_cyc == est_before + 1, "R7", "confirm-to-poll gap",
          first_rd - d0_cyc, est_before + 1);
  endtask

  // ---------------- sequence ----------------
  initial begin
    int wd;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk(!busy && !done && !din_ready && !fl_we && !fl_re && err_code == 3'd0,
        "R11", "reset outputs", {busy, done, din_ready, fl_we, fl_re, err_code}, 0);
    chk(wait_est == 6'(EINIT), "R11", "reset estimate", wait_est, EINIT);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_case(VEC[v][39:24], VEC[v][23:16], VEC[v][15], VEC[v][14],
               int'(VEC[v][13:9]), int'(VEC[v][8:4]), VEC[v][3], VEC[v][2:0]);
    end

    // R9 floor: repeated quick completions pin the estimate at 1
    for (int r = 0; r < 5; r++) run_case(16'h0300, 8'd2, 1'b1, 1'b0, 0, 0, 1'b0, 3'd0);
    chk(wait_est == 6'd1, "R9", "estimate floor", wait_est, 1);

    // R5: single odd byte in a fresh window, count word zero
    run_case(16'h0400, 8'd1, 1'b1, 1'b0, 0, 1, 1'b0, 3'd0);

    wd = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // global watchdog
  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule